// File: doc/BRIEF.md
# Condition-Code Branch Resolver with Delay-Slot Annul

This block resolves conditional branches for a pipeline that has a delay slot after every branch. It keeps four integer condition flags: negative, zero, overflow and carry/borrow. A condition-setting subtract of two operands refreshes them. Each presented instruction word is checked for the branch format. For a branch, the block selects one of sixteen tests over the stored flags and decides whether the branch is taken. It also computes the target address from the branch PC and the displacement.

It also reports whether the instruction in the delay slot must be squashed. Conditional branches squash the slot only when the annul bit is set and the branch falls through. The unconditional forms (always, never) squash the slot whenever the annul bit is set. Results are registered and appear one clock after the instruction is presented.

Top module: `ccbr_unit`

## Requirements
- R1: While `rst` is high the result outputs are all zero. After reset the flags read as N=0, Z=0, V=0, C=0.
- R2: When `cc_we` is high, the flags take the value of `cc_opa - cc_opb` (32 bits):
  - N is bit 31 of the difference.
  - Z is 1 when the difference is zero.
  - V is signed overflow of the subtract.
  - C is the borrow, meaning `cc_opa < cc_opb` unsigned.
- R3: A flag update has no effect on a branch presented in the same cycle. It applies to branches from the next cycle on, and the flags hold while `cc_we` is low.
- R4: An instruction is a branch only when `br_valid` is high, bits 31:30 equal 2'b00 and bits 24:22 equal 3'b010. Otherwise `res_valid`, `res_taken`, `res_annul` and `res_target` are all zero in the result cycle.
- R5: `res_target` is the branch PC plus the sign-extended displacement in bits 21:0, shifted left by 2, modulo 2^32.
- R6: The condition field is bits 28:25. The tests for codes 1 to 7 are:
  - 1: Z
  - 2: Z or (N xor V)
  - 3: N xor V
  - 4: C or Z
  - 5: C
  - 6: N
  - 7: V
- R7: Codes 9 to 15 are the logical complements of codes 1 to 7, in the same order.
- R8: For codes other than 0 and 8, `res_annul` is 1 exactly when bit 29 (annul bit) is 1 and the branch is not taken.
- R9: Code 8 (always) is always taken, and `res_annul` equals the annul bit.
- R10: Code 0 (never) is never taken, and `res_annul` equals the annul bit.
- R11: Every result appears on the outputs exactly one clock edge after the instruction is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | An instruction is presented |
| br_insn | input | 32 | Instruction word |
| br_pc | input | 32 | Address of the instruction |
| cc_we | input | 1 | Flag update strobe |
| cc_opa | input | 32 | Subtract minuend |
| cc_opb | input | 32 | Subtract subtrahend |
| res_valid | output | 1 | Result describes a branch |
| res_taken | output | 1 | Branch is taken |
| res_target | output | 32 | Branch target address |
| res_annul | output | 1 | Squash the delay-slot instruction |

## Verification
Every result is due one edge after its instruction is sampled. A flag write is due one edge after its strobe and is first visible through a branch sampled on that edge. The reference model evaluates each sampled instruction on the rising edge, using the flags it held before that edge, and only then applies any pending update. The outputs are compared on the following falling edge, once the result register has settled. This keeps the same-cycle update case (R3) exact.

// File: rtl/ccbr_pkg.sv
package ccbr_pkg;

    localparam int XLEN    = 32;
    localparam int DISP_W  = 22;
    localparam int COND_W  = 4;
    localparam int OFF_W   = DISP_W + 2;
    localparam int SEXT_W  = XLEN - OFF_W;

    localparam logic [1:0] BR_OP  = 2'b00;
    localparam logic [2:0] BR_OP2 = 3'b010;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_flags_t;

    typedef enum logic [COND_W-1:0] {
        CC_NEVER  = 4'd0,
        CC_EQ     = 4'd1,
        CC_LE     = 4'd2,
        CC_LT     = 4'd3,
        CC_LEU    = 4'd4,
        CC_CS     = 4'd5,
        CC_NEG    = 4'd6,
        CC_VS     = 4'd7,
        CC_ALWAYS = 4'd8,
        CC_NE     = 4'd9,
        CC_GT     = 4'd10,
        CC_GE     = 4'd11,
        CC_GU     = 4'd12,
        CC_CC     = 4'd13,
        CC_POS    = 4'd14,
        CC_VC     = 4'd15
    } cc_cond_e;

    typedef struct packed {
        logic             hit;
        logic             annul_bit;
        cc_cond_e         cond;
        logic [XLEN-1:0]  target;
    } br_dec_t;

    typedef struct packed {
        logic             valid;
        logic             taken;
        logic             annul;
        logic [XLEN-1:0]  target;
    } br_res_t;

    function automatic cc_flags_t sub_flags(input logic [XLEN-1:0] a,
                                            input logic [XLEN-1:0] b);
        cc_flags_t      f;
        logic [XLEN:0]  wide;
        wide = {1'b0, a} - {1'b0, b};
        f.n  = wide[XLEN-1];
        f.z  = (wide[XLEN-1:0] == '0);
        f.v  = (a[XLEN-1] != b[XLEN-1]) && (wide[XLEN-1] != a[XLEN-1]);
        f.c  = wide[XLEN];
        return f;
    endfunction

    function automatic logic base_test(input cc_flags_t f, input logic [2:0] sel);
        logic r;
        unique case (sel)
            3'd0: r = 1'b0;
            3'd1: r = f.z;
            3'd2: r = f.z | (f.n ^ f.v);
            3'd3: r = f.n ^ f.v;
            3'd4: r = f.c | f.z;
            3'd5: r = f.c;
            3'd6: r = f.n;
            default: r = f.v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ccbr_flags.sv
module ccbr_flags
    import ccbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    output cc_flags_t        flags_q
);

    cc_flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (we) flags_d = sub_flags(opa, opb);
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    // R2
    eq_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (we && opa == opb) |=> (flags_q.z && !flags_q.c && !flags_q.n && !flags_q.v));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(flags_q));

endmodule

// File: rtl/ccbr_decode.sv
module ccbr_decode
    import ccbr_pkg::*;
(
    input  logic             valid,
    input  logic [31:0]      insn,
    input  logic [XLEN-1:0]  pc,
    output br_dec_t          dec
);

    logic [DISP_W-1:0] disp;
    logic [XLEN-1:0]   offset;

    assign disp   = insn[DISP_W-1:0];
    assign offset = {{SEXT_W{disp[DISP_W-1]}}, disp, 2'b00};

    always_comb begin
        dec.hit       = valid && (insn[31:30] == BR_OP) && (insn[24:22] == BR_OP2);
        dec.annul_bit = insn[29];
        dec.cond      = cc_cond_e'(insn[28:25]);
        dec.target    = pc + offset;
    end

endmodule

// File: rtl/ccbr_cond_eval.sv
module ccbr_cond_eval
    import ccbr_pkg::*;
(
    input  cc_flags_t  flags,
    input  cc_cond_e   cond,
    input  logic       annul_bit,
    output logic       taken,
    output logic       annul
);

    logic base;
    logic uncond;

    assign base   = base_test(flags, cond[2:0]);
    assign taken  = cond[3] ? ~base : base;
    assign uncond = (cond[2:0] == 3'd0);
    assign annul  = uncond ? annul_bit : (annul_bit & ~taken);

    // R7
    always_comb begin
        if (cond == CC_ALWAYS) complement_chk: assert (taken);
    end

endmodule

// File: rtl/ccbr_unit.sv
module ccbr_unit
    import ccbr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         br_valid,
    input  logic [31:0]  br_insn,
    input  logic [31:0]  br_pc,
    input  logic         cc_we,
    input  logic [31:0]  cc_opa,
    input  logic [31:0]  cc_opb,
    output logic         res_valid,
    output logic         res_taken,
    output logic [31:0]  res_target,
    output logic         res_annul
);

    cc_flags_t flags_q;
    br_dec_t   dec;
    logic      ev_taken;
    logic      ev_annul;
    br_res_t   res_d;
    br_res_t   res_q;

    ccbr_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .we      (cc_we),
        .opa     (cc_opa),
        .opb     (cc_opb),
        .flags_q (flags_q)
    );

    ccbr_decode u_dec (
        .valid (br_valid),
        .insn  (br_insn),
        .pc    (br_pc),
        .dec   (dec)
    );

    ccbr_cond_eval u_eval (
        .flags     (flags_q),
        .cond      (dec.cond),
        .annul_bit (dec.annul_bit),
        .taken     (ev_taken),
        .annul     (ev_annul)
    );

    always_comb begin
        res_d = '0;
        if (dec.hit) begin
            res_d.valid  = 1'b1;
            res_d.taken  = ev_taken;
            res_d.annul  = ev_annul;
            res_d.target = dec.target;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign res_valid  = res_q.valid;
    assign res_taken  = res_q.taken;
    assign res_annul  = res_q.annul;
    assign res_target = res_q.target;

    // R9
    always_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.hit && dec.cond == CC_ALWAYS) |=> (res_taken && res_annul == $past(dec.annul_bit)));

    // R10
    never_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.hit && dec.cond == CC_NEVER) |=> (!res_taken && res_annul == $past(dec.annul_bit)));

    // R4
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !dec.hit |=> (!res_valid && !res_taken && !res_annul && res_target == '0));

    // R8
    no_annul_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.hit && !dec.annul_bit) |=> !res_annul);

    // R11
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        dec.hit |=> res_valid);

endmodule

// File: tb/ccbr_unit_tb_top.sv
`timescale 1ns/1ps
module ccbr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_valid = 1'b0;
    logic [31:0] br_insn = '0;
    logic [31:0] br_pc = '0;
    logic        cc_we = 1'b0;
    logic [31:0] cc_opa = '0;
    logic [31:0] cc_opb = '0;
    logic        res_valid, res_taken, res_annul;
    logic [31:0] res_target;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    ccbr_unit dut_i (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_insn(br_insn), .br_pc(br_pc),
        .cc_we(cc_we), .cc_opa(cc_opa), .cc_opb(cc_opb),
        .res_valid(res_valid), .res_taken(res_taken),
        .res_target(res_target), .res_annul(res_annul)
    );

    // Reference state: the last subtract operands stand in for the flags.
    // Reset operands 1 - 0 give N=Z=V=C=0 (R1).
    logic [31:0] m_a = 32'd1;
    logic [31:0] m_b = 32'd0;
    logic        e_valid = 0, e_taken = 0, e_annul = 0;
    logic [31:0] e_target = '0;
    logic [3:0]  e_cond = '0;

    function automatic bit ref_test(input logic [31:0] a, input logic [31:0] b,
                                    input logic [3:0] code);
        bit eq, slt, ult, neg, ovf, r;
        logic [31:0] diff;
        longint sd;
        eq   = (a == b);
        slt  = $signed(a) < $signed(b);
        ult  = a < b;
        diff = a - b;
        neg  = diff[31];
        sd   = longint'($signed(a)) - longint'($signed(b));
        ovf  = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
        case (code[2:0])
            3'd0: r = 0;
            3'd1: r = eq;
            3'd2: r = slt | eq;
            3'd3: r = slt;
            3'd4: r = ult | eq;
            3'd5: r = ult;
            3'd6: r = neg;
            default: r = ovf;
        endcase
        return code[3] ? !r : r;
    endfunction

    // R3 R11: evaluate with the flags held before this edge, then update.
    always @(posedge clk) begin
        if (rst) begin
            e_valid = 0; e_taken = 0; e_annul = 0; e_target = '0; e_cond = '0;
            m_a = 32'd1; m_b = 32'd0;
        end else begin
            started = 1;
            e_valid = br_valid && br_insn[31:30] == 2'b00 && br_insn[24:22] == 3'b010;
            e_cond  = br_insn[28:25];
            if (e_valid) begin
                e_taken  = ref_test(m_a, m_b, e_cond);
                e_annul  = (e_cond == 4'd0 || e_cond == 4'd8) ? br_insn[29]
                                                              : (br_insn[29] && !e_taken);
                e_target = br_pc + {{8{br_insn[21]}}, br_insn[21:0], 2'b00};
            end else begin
                e_taken = 0; e_annul = 0; e_target = '0;
            end
            if (cc_we) begin
                m_a = cc_opa; m_b = cc_opb;   // R2 applied for later branches
            end
        end
    end

    function automatic string cond_tag(input logic v, input logic [3:0] c);
        if (!v) return "R4";
        if (c == 4'd0) return "R10";
        if (c == 4'd8) return "R9";
        if (c > 4'd8) return "R7";
        return "R6";
    endfunction

    always @(negedge clk) begin
        if (started && !done) begin
            total++;
            if (res_valid !== e_valid || res_taken !== e_taken) begin
                bad++;
                $display("FAIL %s cond=%0d valid/taken act=%b%b exp=%b%b",
                         cond_tag(e_valid, e_cond), e_cond, res_valid, res_taken, e_valid, e_taken);
            end
            total++;
            if (res_annul !== e_annul) begin
                bad++;
                $display("FAIL %s annul cond=%0d act=%b exp=%b",
                         (e_valid && e_cond != 0 && e_cond != 8) ? "R8" : cond_tag(e_valid, e_cond),
                         e_cond, res_annul, e_annul);
            end
            total++;
            if (res_target !== e_target) begin
                bad++;
                $display("FAIL %s target act=%h exp=%h", e_valid ? "R5" : "R4", res_target, e_target);
            end
        end
    end

    function automatic logic [31:0] mk_br(input bit ab, input logic [3:0] c, input logic [21:0] d);
        return {2'b00, ab, c, 3'b010, d};
    endfunction

    task automatic drive(input bit we, input logic [31:0] a, input logic [31:0] b,
                         input bit v, input logic [31:0] insn, input logic [31:0] pc);
        @(negedge clk);
        cc_we = we; cc_opa = a; cc_opb = b;
        br_valid = v; br_insn = insn; br_pc = pc;
    endtask

    logic [31:0] pa [8] = '{32'd5, 32'd3, 32'd7, 32'h8000_0000,
                            32'h7fff_ffff, 32'd0, 32'hffff_ffff, 32'h8000_0000};
    logic [31:0] pb [8] = '{32'd5, 32'd7, 32'd3, 32'd1,
                            32'hffff_ffff, 32'hffff_ffff, 32'd0, 32'h8000_0000};

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs zero under reset
        total++;
        if (res_valid !== 0 || res_taken !== 0 || res_annul !== 0 || res_target !== 0) begin
            bad++;
            $display("FAIL R1 reset outputs act=%b%b%b %h exp=000 0",
                     res_valid, res_taken, res_annul, res_target);
        end
        @(negedge clk); rst = 0;
        // R1: branches against the cleared flags
        for (int c = 0; c < 16; c++) drive(0, 0, 0, 1, mk_br(c[0], c[3:0], 22'h3ffff0), 32'h100);
        // R2 R6 R7 R8 R9 R10: every code with both annul settings per flag pattern
        for (int p = 0; p < 8; p++) begin
            // R3: update and branch together; branch sees prior flags
            drive(1, pa[p], pb[p], 1, mk_br(1, 4'd1, 22'd4), 32'h2000);
            for (int c = 0; c < 16; c++)
                for (int ab = 0; ab < 2; ab++)
                    drive(0, 0, 0, 1, mk_br(ab[0], c[3:0], 22'($urandom)), $urandom);
        end
        // R4: not a branch
        drive(0, 0, 0, 1, {2'b01, 30'h3fff_ffff}, 32'h40);
        drive(0, 0, 0, 1, {2'b00, 1'b1, 4'd8, 3'b100, 22'h1}, 32'h40);
        drive(0, 0, 0, 0, mk_br(1, 4'd8, 22'h10), 32'h40);
        // R5: target wrap around both ends
        drive(0, 0, 0, 1, mk_br(0, 4'd8, 22'h200000), 32'h4);
        drive(0, 0, 0, 1, mk_br(0, 4'd8, 22'h1fffff), 32'hffff_fff0);
        // Mixed traffic
        for (int i = 0; i < 3000; i++)
            drive($urandom_range(0, 3) == 0, $urandom_range(0, 1) ? $urandom : $urandom_range(0, 4),
                  $urandom_range(0, 1) ? $urandom : $urandom_range(0, 4),
                  $urandom_range(0, 7) != 0,
                  $urandom_range(0, 5) == 0 ? $urandom : mk_br(1'($urandom), 4'($urandom), 22'($urandom)),
                  $urandom);
        drive(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule